// File: doc/BRIEF.md
# Alignment-Stepping Copy and Fill Engine

This block is a bus master that moves a region of memory to another place (copy) or writes one repeated byte over a region (fill). It takes its job from a small set of configuration inputs: source address, destination address, byte count, pattern byte and a copy/fill select. A one-cycle start pulse launches the job. From then on the engine issues its own memory requests until the last byte has been written, and it raises a done flag at the end.

Each step picks the widest access the destination address and the remaining count allow: 1, 2, 4 or 8 bytes. An unaligned start therefore steps up through narrow accesses until it reaches an 8-byte boundary. The bulk of the region moves in 8-byte accesses, and the tail steps down through narrower ones. Some jobs cannot use this stepping. A short job runs entirely in byte accesses. So does a copy whose source and destination sit at different offsets within an 8-byte word.

Top module: `mem_copy_engine`

## Requirements
- R1: A start pulse while idle loads the configuration. Busy is high and done is low one cycle later. Busy falls in the cycle after the last write is accepted, and done rises in that same cycle. Done stays high until the next accepted start.
- R2: In copy mode, after busy falls, every destination byte holds the source byte at the same offset. No byte outside the destination range has changed.
- R3: In fill mode, after busy falls, every byte of the destination range holds the 8-bit pattern. No other byte has changed.
- R4: Each access size is encoded as 0=1 byte, 1=2 bytes, 2=4 bytes, 3=8 bytes. The engine uses the largest size whose byte count divides the current destination address and does not exceed the remaining count. This gives a step-up, a cruise at 8 bytes, and a step-down.
- R5: A job shorter than SHORT_LEN bytes (default 8) uses only 1-byte accesses.
- R6: A copy whose source and destination differ in address bits [2:0] uses only 1-byte accesses for the whole job.
- R7: A zero-length start raises done one cycle later. It issues no requests and leaves busy low.
- R8: A start pulse while busy has no effect on the running job or on memory.
- R9: A request holds valid, address, size and write unchanged until ready. Its address is a multiple of its size. Its strobes mark the 2^size bytes beginning at lane address[2:0] of the 64-bit data bus. Read data bytes return on the lanes given by their address bits [2:0], at least one cycle after the read is accepted.
- R10: In copy mode, each write is preceded by a read of the same size from the source, and the read and write counts are equal. Fill mode issues no reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch pulse |
| cfg_fill | input | 1 | 1 = fill, 0 = copy |
| cfg_src | input | ADDR_W | Source byte address |
| cfg_dst | input | ADDR_W | Destination byte address |
| cfg_len | input | LEN_W | Byte count |
| cfg_pattern | input | 8 | Fill byte |
| busy | output | 1 | Job in progress |
| done | output | 1 | Last job finished |
| req_valid | output | 1 | Memory request valid |
| req_ready | input | 1 | Memory accepts request |
| req_write | output | 1 | 1 = write, 0 = read |
| req_addr | output | ADDR_W | Byte address of access |
| req_size | output | 2 | log2 of access bytes |
| req_strb | output | 8 | Byte-lane enables |
| req_wdata | output | 64 | Write data, lane-placed |
| rsp_valid | input | 1 | Read data valid |
| rsp_rdata | input | 64 | Read data, lane-placed |

## Verification
Busy and the cleared done flag appear one cycle after the start pulse, and the bench samples them at the next falling edge. A zero-length start shows done at that same sample, and the bench waits several cycles more to confirm that no request was logged. Memory contents and the logged sequence of access sizes are settled once busy has fallen. The bench waits for that fall, checks done at the same sample, and then compares the logged sizes and the memory against an arithmetic model of the stepping rule. The memory model accepts requests under a pseudo-random ready and returns read data one cycle after accept, so the request-hold and ordering rules are checked under stalls.

// File: rtl/mce_pkg.sv
package mce_pkg;

    localparam int LANES  = 8;
    localparam int DATA_W = 64;

    typedef enum logic [1:0] {
        SZ_B = 2'd0,
        SZ_H = 2'd1,
        SZ_W = 2'd2,
        SZ_D = 2'd3
    } xfer_size_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RD    = 2'd1,
        ST_RWAIT = 2'd2,
        ST_WR    = 2'd3
    } eng_state_e;

    typedef struct packed {
        logic        fill;
        logic        byte_only;
        logic [7:0]  pattern;
    } job_mode_t;

    // widest size legal for the lane offset and remaining count
    function automatic xfer_size_e pick_size(
        input logic [2:0] lo,
        input logic       ge8,
        input logic       ge4,
        input logic       ge2,
        input logic       byte_only
    );
        xfer_size_e s;
        if (byte_only)                   s = SZ_B;
        else if (lo == 3'd0 && ge8)      s = SZ_D;
        else if (lo[1:0] == 2'd0 && ge4) s = SZ_W;
        else if (lo[0] == 1'b0 && ge2)   s = SZ_H;
        else                             s = SZ_B;
        return s;
    endfunction

    function automatic logic [3:0] size_bytes(input xfer_size_e s);
        logic [3:0] b;
        case (s)
            SZ_B:    b = 4'd1;
            SZ_H:    b = 4'd2;
            SZ_W:    b = 4'd4;
            default: b = 4'd8;
        endcase
        return b;
    endfunction

    function automatic logic [7:0] lane_strb(input logic [2:0] lo, input xfer_size_e s);
        logic [7:0] m;
        case (s)
            SZ_B:    m = 8'h01;
            SZ_H:    m = 8'h03;
            SZ_W:    m = 8'h0f;
            default: m = 8'hff;
        endcase
        return m << lo;
    endfunction

endpackage

// File: rtl/mce_step_sel.sv
module mce_step_sel
    import mce_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic [2:0]       lo,
    input  logic [LEN_W-1:0] remaining,
    input  logic             byte_only,
    output xfer_size_e       size,
    output logic [3:0]       nbytes
);
    logic ge8, ge4, ge2;

    always_comb begin
        ge8    = remaining >= LEN_W'(8);
        ge4    = remaining >= LEN_W'(4);
        ge2    = remaining >= LEN_W'(2);
        size   = pick_size(lo, ge8, ge4, ge2, byte_only);
        nbytes = size_bytes(size);
    end
endmodule

// File: rtl/mce_lane_mux.sv
module mce_lane_mux
    import mce_pkg::*;
(
    input  logic [DATA_W-1:0] rdata,
    input  logic [2:0]        src_lo,
    input  logic [2:0]        dst_lo,
    input  logic              fill,
    input  logic [7:0]        pattern,
    output logic [DATA_W-1:0] wdata
);
    logic [DATA_W-1:0] pat_word;
    logic [DATA_W-1:0] shifted;

    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_rep
            assign pat_word[g*8 +: 8] = pattern;
        end
    endgenerate

    always_comb begin
        shifted = (rdata >> {src_lo, 3'b000}) << {dst_lo, 3'b000};
        wdata   = fill ? pat_word : shifted;
    end
endmodule

// File: rtl/mem_copy_engine.sv
module mem_copy_engine
    import mce_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int LEN_W     = 16,
    parameter int SHORT_LEN = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              cfg_fill,
    input  logic [ADDR_W-1:0] cfg_src,
    input  logic [ADDR_W-1:0] cfg_dst,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic [7:0]        cfg_pattern,
    output logic              busy,
    output logic              done,
    output logic              req_valid,
    input  logic              req_ready,
    output logic              req_write,
    output logic [ADDR_W-1:0] req_addr,
    output logic [1:0]        req_size,
    output logic [7:0]        req_strb,
    output logic [63:0]       req_wdata,
    input  logic              rsp_valid,
    input  logic [63:0]       rsp_rdata
);
    eng_state_e        state_q;
    logic [ADDR_W-1:0] src_q, dst_q;
    logic [LEN_W-1:0]  rem_q;
    job_mode_t         mode_q;
    logic [DATA_W-1:0] data_q;
    logic              done_q;

    xfer_size_e        cur_size;
    logic [3:0]        cur_bytes;
    logic [LEN_W-1:0]  step_len;
    logic [ADDR_W-1:0] step_addr;
    logic              cfg_byte_only;
    logic              last_step;

    mce_step_sel #(.LEN_W(LEN_W)) i_step (
        .lo        (dst_q[2:0]),
        .remaining (rem_q),
        .byte_only (mode_q.byte_only),
        .size      (cur_size),
        .nbytes    (cur_bytes)
    );

    mce_lane_mux i_lanes (
        .rdata   (data_q),
        .src_lo  (src_q[2:0]),
        .dst_lo  (dst_q[2:0]),
        .fill    (mode_q.fill),
        .pattern (mode_q.pattern),
        .wdata   (req_wdata)
    );

    always_comb begin
        step_len      = LEN_W'(cur_bytes);
        step_addr     = ADDR_W'(cur_bytes);
        last_step     = (rem_q == step_len);
        cfg_byte_only = (cfg_len < LEN_W'(SHORT_LEN)) ||
                        (!cfg_fill && (cfg_src[2:0] != cfg_dst[2:0]));
        req_valid     = (state_q == ST_RD) || (state_q == ST_WR);
        req_write     = (state_q == ST_WR);
        req_addr      = req_write ? dst_q : src_q;
        req_size      = cur_size;
        req_strb      = lane_strb(req_addr[2:0], cur_size);
        busy          = (state_q != ST_IDLE);
        done          = done_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            src_q   <= '0;
            dst_q   <= '0;
            rem_q   <= '0;
            mode_q  <= '0;
            data_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        src_q  <= cfg_src;
                        dst_q  <= cfg_dst;
                        rem_q  <= cfg_len;
                        mode_q <= '{fill: cfg_fill, byte_only: cfg_byte_only,
                                    pattern: cfg_pattern};
                        if (cfg_len == '0) begin
                            done_q <= 1'b1;
                        end else begin
                            done_q  <= 1'b0;
                            state_q <= cfg_fill ? ST_WR : ST_RD;
                        end
                    end
                end
                ST_RD: begin
                    if (req_ready) state_q <= ST_RWAIT;
                end
                ST_RWAIT: begin
                    if (rsp_valid) begin
                        data_q  <= rsp_rdata;
                        state_q <= ST_WR;
                    end
                end
                default: begin
                    if (req_ready) begin
                        src_q <= src_q + step_addr;
                        dst_q <= dst_q + step_addr;
                        rem_q <= rem_q - step_len;
                        if (last_step) begin
                            state_q <= ST_IDLE;
                            done_q  <= 1'b1;
                        end else begin
                            state_q <= mode_q.fill ? ST_WR : ST_RD;
                        end
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/mce_checker.sv
module mce_checker #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic [LEN_W-1:0]  cfg_len,
    input logic              busy,
    input logic              done,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [1:0]        req_size,
    input logic [7:0]        req_strb
);
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        req_valid && !req_ready |=> req_valid && $stable(req_addr) &&
                                    $stable(req_size) && $stable(req_write));

    p_align_r4: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> (req_addr[2:0] & ((3'd1 << req_size) - 3'd1)) == 3'd0);

    p_strb_r9: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> $countones(req_strb) == (32'd1 << req_size));

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !req_valid);

    p_done_at_end_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    p_zero_len_r7: assert property (@(posedge clk) disable iff (rst)
        start && !busy && cfg_len == '0 |=> done && !busy && !req_valid);

    p_start_ignored_r8: assert property (@(posedge clk) disable iff (rst)
        busy && start && !(req_valid && req_ready && req_write) |=> busy);
endmodule

bind mem_copy_engine mce_checker #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) i_mce_checker (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .cfg_len   (cfg_len),
    .busy      (busy),
    .done      (done),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_size  (req_size),
    .req_strb  (req_strb)
);

// File: tb/test_mem_copy_engine.sv
module test_mem_copy_engine;
    localparam int AW = 32;
    localparam int LW = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic          start = 1'b0, cfg_fill = 1'b0;
    logic [AW-1:0] cfg_src = '0, cfg_dst = '0;
    logic [LW-1:0] cfg_len = '0;
    logic [7:0]    cfg_pattern = '0;
    logic          busy, done, req_valid, req_write;
    logic          req_ready = 1'b0;
    logic [AW-1:0] req_addr;
    logic [1:0]    req_size;
    logic [7:0]    req_strb;
    logic [63:0]   req_wdata;
    logic          rsp_valid = 1'b0;
    logic [63:0]   rsp_rdata = '0;

    mem_copy_engine #(.ADDR_W(AW), .LEN_W(LW)) i_mem_copy_engine (.*);

    // memory model
    logic [7:0] mem [0:255];
    logic [1:0] wr_log [0:63];
    logic [1:0] rd_log [0:63];
    int         wr_n = 0, rd_n = 0;
    logic       init_req = 1'b0, log_clr = 1'b0;
    logic [7:0] lfsr = 8'h5a;

    function automatic logic [7:0] initv(input int i);
        return 8'((i * 37 + 11) & 255);
    endfunction

    always @(posedge clk) begin
        lfsr      <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        req_ready <= lfsr[0] | lfsr[2];
        rsp_valid <= 1'b0;
        if (init_req) for (int i = 0; i < 256; i++) mem[i] <= initv(i);
        if (log_clr) begin
            wr_n <= 0;
            rd_n <= 0;
        end else if (req_valid && req_ready) begin
            if (req_write) begin
                for (int b = 0; b < 8; b++)
                    if (req_strb[b]) mem[{req_addr[7:3], 3'(b)}] <= req_wdata[b*8 +: 8];
                if (wr_n < 64) wr_log[wr_n] <= req_size;
                wr_n <= wr_n + 1;
            end else begin
                rsp_valid <= 1'b1;
                for (int b = 0; b < 8; b++)
                    rsp_rdata[b*8 +: 8] <= mem[{req_addr[7:3], 3'(b)}];
                if (rd_n < 64) rd_log[rd_n] <= req_size;
                rd_n <= rd_n + 1;
            end
        end
    end

    int n_checks = 0, n_fail = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // expected step sizes from the stepping rule (R4, R5, R6)
    int exp_sz [0:63];
    int exp_n;
    task automatic calc_exp(input int dst, input int len, input bit bo);
        int a = dst;
        int n = len;
        exp_n = 0;
        while (n > 0) begin
            int s = bo ? 1 : 8;
            while ((a % s) != 0 || s > n) s = s / 2;
            exp_sz[exp_n] = (s == 8) ? 3 : (s == 4) ? 2 : (s == 2) ? 1 : 0;
            exp_n++;
            a += s;
            n -= s;
        end
    endtask

    task automatic prep;
        @(negedge clk);
        init_req = 1'b1;
        log_clr  = 1'b1;
        @(negedge clk);
        init_req = 1'b0;
        log_clr  = 1'b0;
    endtask

    task automatic launch(input bit fill, input int src, input int dst,
                          input int len, input int pat);
        cfg_fill    = fill;
        cfg_src     = AW'(src);
        cfg_dst     = AW'(dst);
        cfg_len     = LW'(len);
        cfg_pattern = 8'(pat);
        start       = 1'b1;
        @(negedge clk);
        start       = 1'b0;
    endtask

    task automatic wait_idle(output bit ok);
        int t = 0;
        while (busy && t < 2000) begin
            @(negedge clk);
            t++;
        end
        ok = !busy;
    endtask

    task automatic verify(input bit fill, input int src, input int dst,
                          input int len, input int pat, input string tag);
        int bad = 0;
        bit bo;
        int sz_bad = 0;
        for (int i = 0; i < 256; i++) begin
            logic [7:0] e;
            if (i >= dst && i < dst + len) e = fill ? 8'(pat) : initv(src + i - dst);
            else e = initv(i);
            if (mem[i] !== e) bad++;
        end
        check(bad == 0, fill ? "R3 fill contents" : "R2 copy contents", bad, 0);
        bo = (len < 8) || (!fill && ((src % 8) != (dst % 8)));
        calc_exp(dst, len, bo);
        check(wr_n == exp_n, {tag, " write count"}, wr_n, exp_n);
        for (int k = 0; k < exp_n && k < 64; k++)
            if (int'(wr_log[k]) != exp_sz[k]) sz_bad++;
        check(sz_bad == 0, {tag, " size sequence"}, sz_bad, 0);
        if (fill) check(rd_n == 0, "R10 fill issues no reads", rd_n, 0);
        else begin
            int rb = 0;
            for (int k = 0; k < rd_n && k < 64; k++) if (rd_log[k] != wr_log[k]) rb++;
            check(rd_n == wr_n && rb == 0, "R10 read per write same size", rd_n, wr_n);
        end
    endtask

    task automatic run_op(input bit fill, input int src, input int dst,
                          input int len, input int pat, input string tag);
        bit ok;
        prep();
        launch(fill, src, dst, len, pat);
        if (len == 0) begin
            check(done && !busy, "R7 zero length done at once", int'(done), 1);
            repeat (4) @(negedge clk);
            check(wr_n == 0 && rd_n == 0 && !busy, "R7 zero length no requests",
                  wr_n + rd_n, 0);
        end else begin
            check(busy && !done, "R1 busy set, done cleared after start",
                  int'(busy), 1);
            wait_idle(ok);
            check(ok && done, "R1 done when busy falls", int'(done), 1);
            verify(fill, src, dst, len, pat, tag);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!busy && !done && !req_valid, "R1 reset state", int'(busy), 0);
        rst = 1'b0;
        @(negedge clk);

        // fill sweep: every lane offset, lengths through the short threshold
        for (int off = 0; off < 8; off++)
            for (int len = 0; len <= 24; len++)
                run_op(1'b1, 0, 8 + off, len, len * 13 + off, "R4 R5 fill");

        // copy sweep with matching offsets
        for (int off = 0; off < 8; off++)
            for (int len = 0; len <= 24; len++)
                run_op(1'b0, 64 + off, 144 + off, len, 0, "R4 R5 copy");

        // copy with differing offsets falls back to bytes
        for (int so = 0; so < 8; so++)
            for (int d = 0; d < 8; d++)
                if (so != d) run_op(1'b0, 64 + so, 144 + d, 13, 0, "R6 byte fallback");

        // long runs with a cruise phase
        run_op(1'b1, 0, 3, 100, 8'h3c, "R4 long fill");
        run_op(1'b0, 5, 133, 100, 0, "R4 long copy");

        // start while busy is ignored (R8)
        begin
            bit ok;
            int bad = 0;
            prep();
            launch(1'b0, 64, 144, 40, 0);
            repeat (3) @(negedge clk);
            launch(1'b1, 0, 16, 8, 8'haa);
            wait_idle(ok);
            check(ok && done, "R8 original job completes", int'(done), 1);
            for (int i = 16; i < 24; i++) if (mem[i] !== initv(i)) bad++;
            check(bad == 0, "R8 second start wrote nothing", bad, 0);
            verify(1'b0, 64, 144, 40, 0, "R8 original job");
            repeat (3) @(negedge clk);
            check(!busy && wr_n == 5, "R8 no job queued", wr_n, 5);
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule